// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides a 32-bit unsigned dividend by a 16-bit unsigned divisor. It produces a 32-bit quotient and a 16-bit remainder such that dividend = divisor * quotient + remainder, with the remainder smaller than the divisor. It uses the restoring method and settles one quotient bit on each clock. One register holds the dividend at the start of an operation. As the dividend bits shift out of its top, the quotient bits shift into its bottom, so the same register holds the quotient when the operation ends.

In each step, the partial remainder shifts left and takes in the top bit of the dividend/quotient register. The divisor is then subtracted from it in a subtractor one bit wider than the divisor. The top bit of the difference does two jobs. It chooses between the difference and the unchanged shifted value for the new partial remainder, and its inverse becomes the new quotient bit.

A caller pulses `start` while the block is idle. `busy` stays high through the 32 steps. `ready` then rises and holds the results until the next accepted start. A step counter is visible on `count`.

Top module: `restoring_divider`

## Requirements
- R1: After a synchronous reset, busy, ready, count, quotient and remainder are all zero.
- R2: A start sampled at a clock edge while busy is low is accepted. After that edge, busy is 1, ready is 0 and count is 0.
- R3: An accepted operation takes exactly 32 further clock edges. After the 32nd edge, ready is 1 and busy is 0.
- R4: While busy, count rises by one at every edge. When the operation completes, count reads 32 (binary 100000).
- R5: When ready is high and the divisor is non-zero, quotient and remainder satisfy dividend = divisor * quotient + remainder, with remainder < divisor.
- R6: 0x4C7F228A / 0x6A0E gives quotient 0x0000B8A6 and remainder 0x4D76. 0x00FFFF00 / 0x0004 gives quotient 0x003FFFC0 and remainder 0.
- R7: A start raised while busy is high is ignored. The count keeps advancing, and the result is that of the operands accepted earlier.
- R8: Once ready is high it stays high, and the quotient and remainder stay unchanged, until the next accepted start. Ready drops at that start.
- R9: busy and ready are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin an operation |
| dividend | input | 32 | Unsigned dividend, sampled on an accepted start |
| divisor | input | 16 | Unsigned divisor, sampled on an accepted start |
| quotient | output | 32 | Quotient, valid while ready is high |
| remainder | output | 16 | Remainder, valid while ready is high |
| busy | output | 1 | Operation in progress |
| ready | output | 1 | Results valid |
| count | output | 6 | Number of steps completed in the current operation |

## Verification
The start edge counts as edge zero. Ready and the results are due after edge 32, so they are first seen at the falling edge that follows it, 33 bench cycles after the start was driven. The busy, ready and count values that follow an accepted start are due after edge zero and are sampled at the next falling edge. The bench stamps each queued operation with the cycle in which it was driven. The monitor compares that stamp with the cycle in which ready rises, so a step too many or too few is caught as well as a wrong value. A start raised mid-operation is checked through the count it must not reset and through the result it must not change.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    localparam int unsigned RDIV_NUM_W = 32;
    localparam int unsigned RDIV_DEN_W = 16;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } rdiv_phase_e;

    function automatic int unsigned rdiv_cnt_w(input int unsigned steps);
        return $clog2(steps + 1);
    endfunction

endpackage

// File: rtl/rdiv_trial.sv
module rdiv_trial #(
    parameter int unsigned RW = 16
) (
    input  logic [RW-1:0] part_rem,
    input  logic          next_bit,
    input  logic [RW-1:0] den,
    output logic [RW-1:0] new_rem,
    output logic          q_bit
);
    localparam int unsigned SW = RW + 1;

    logic [SW-1:0] shifted;
    logic [SW-1:0] diff;
    logic          neg;

    always_comb begin
        shifted = {part_rem, next_bit};
        diff    = shifted - {1'b0, den};
        neg     = diff[SW-1];
        new_rem = neg ? shifted[RW-1:0] : diff[RW-1:0];
        q_bit   = ~neg;
    end
endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
    import rdiv_pkg::*;
#(
    parameter int unsigned STEPS = 32,
    parameter int unsigned CW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          load,
    output logic          step,
    output logic          busy,
    output logic          ready,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    rdiv_phase_e phase;

    assign busy = (phase == PH_RUN);
    assign load = start && !busy;
    assign step = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            ready <= 1'b0;
            count <= '0;
        end else if (load) begin
            phase <= PH_RUN;
            ready <= 1'b0;
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
            if (count == LAST) begin
                phase <= PH_IDLE;
                ready <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rdiv_regs.sv
module rdiv_regs #(
    parameter int unsigned AW = 32,
    parameter int unsigned RW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] a_in,
    input  logic [RW-1:0] b_in,
    input  logic          q_bit,
    input  logic [RW-1:0] new_rem,
    output logic [AW-1:0] num_q,
    output logic [RW-1:0] rem_q,
    output logic [RW-1:0] den_q,
    output logic          top_bit
);
    assign top_bit = num_q[AW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q <= '0;
            rem_q <= '0;
            den_q <= '0;
        end else if (load) begin
            num_q <= a_in;
            rem_q <= '0;
            den_q <= b_in;
        end else if (step) begin
            num_q <= {num_q[AW-2:0], q_bit};
            rem_q <= new_rem;
        end
    end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
    import rdiv_pkg::*;
#(
    parameter int unsigned AW = RDIV_NUM_W,
    parameter int unsigned RW = RDIV_DEN_W,
    parameter int unsigned CW = rdiv_cnt_w(RDIV_NUM_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] dividend,
    input  logic [RW-1:0] divisor,
    output logic [AW-1:0] quotient,
    output logic [RW-1:0] remainder,
    output logic          busy,
    output logic          ready,
    output logic [CW-1:0] count
);
    logic          load;
    logic          step;
    logic          top_bit;
    logic          q_bit;
    logic [RW-1:0] new_rem;
    logic [RW-1:0] rem_q;
    logic [RW-1:0] den_q;
    logic [AW-1:0] num_q;

    rdiv_ctrl #(.STEPS(AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .load(load), .step(step), .busy(busy), .ready(ready), .count(count)
    );

    rdiv_regs #(.AW(AW), .RW(RW)) u_regs (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .a_in(dividend), .b_in(divisor), .q_bit(q_bit), .new_rem(new_rem),
        .num_q(num_q), .rem_q(rem_q), .den_q(den_q), .top_bit(top_bit)
    );

    rdiv_trial #(.RW(RW)) u_trial (
        .part_rem(rem_q), .next_bit(top_bit), .den(den_q),
        .new_rem(new_rem), .q_bit(q_bit)
    );

    assign quotient  = num_q;
    assign remainder = rem_q;
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
    parameter int unsigned AW = 32,
    parameter int unsigned RW = 16,
    parameter int unsigned CW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [AW-1:0] quotient,
    input logic [RW-1:0] remainder,
    input logic          busy,
    input logic          ready,
    input logic [CW-1:0] count,
    input logic [RW-1:0] den_hold
);
    localparam logic [CW-1:0] LAST = CW'(AW - 1);

    p_busy_ready_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(busy && ready));

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !ready && count == '0));

    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        busy |=> (count == $past(count) + 1'b1));

    p_finish_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && count == LAST) |=> (ready && !busy));

    p_ignore_start_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && count != LAST) |=> busy);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> (ready && $stable(quotient) && $stable(remainder)));

    p_rem_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (ready && den_hold != '0) |-> (remainder < den_hold));
endmodule

bind restoring_divider rdiv_checker #(.AW(AW), .RW(RW), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .quotient(quotient),
    .remainder(remainder), .busy(busy), .ready(ready), .count(count),
    .den_hold(den_q)
);

// File: tb/restoring_divider_bench.sv
`timescale 1ns/1ps
module restoring_divider_bench;
    typedef struct {
        logic [31:0] a;
        logic [15:0] b;
        logic [31:0] q;
        logic [15:0] r;
        int          t0;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [31:0] quotient;
    logic [15:0] remainder;
    logic        busy, ready;
    logic [5:0]  count;

    item_t exp_q[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic prev_ready = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    restoring_divider u_restoring_divider (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend),
        .divisor(divisor), .quotient(quotient), .remainder(remainder),
        .busy(busy), .ready(ready), .count(count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [15:0] b);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        it.a = a; it.b = b; it.q = a / {16'h0, b}; it.r = 16'(a % {16'h0, b});
        it.t0 = cyc;
        exp_q.push_back(it);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: scoreboard compare on each ready rise
    always @(negedge clk) begin
        if (!rst && ready && !prev_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected result", 1, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(cyc - it.t0 == 33, "R3", "latency", cyc - it.t0, 33);
                check(!busy, "R9", "busy at ready", busy, 0);
                check(count == 6'd32, "R4", "final count", count, 32);
                check(quotient == it.q, "R5", "quotient", quotient, it.q);
                check(remainder == it.r, "R5", "remainder", remainder, it.r);
            end
        end
        prev_ready <= ready;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : driver
        logic [31:0] lcg;
        logic [31:0] held_q;
        logic [15:0] held_r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !ready && count == 0, "R1", "status", {busy, ready, count}, 0);
        check(quotient == 0 && remainder == 0, "R1", "data", quotient, 0);

        // R6 worked examples, R2 accept
        issue(32'h4C7F228A, 16'h6A0E);
        check(busy && !ready && count == 0, "R2", "after accept", {busy, ready, count}, 8'h80);
        drain();
        check(quotient == 32'h0000B8A6 && remainder == 16'h4D76, "R6", "example one",
              quotient, 32'hB8A6);
        issue(32'h00FFFF00, 16'h0004);
        drain();
        check(quotient == 32'h003FFFC0 && remainder == 16'h0, "R6", "example two",
              quotient, 32'h3FFFC0);

        // R8 hold, then drop on new start
        held_q = quotient; held_r = remainder;
        repeat (6) @(negedge clk);
        check(ready && quotient == held_q && remainder == held_r, "R8", "hold",
              quotient, held_q);
        issue(32'd1000, 16'd7);
        check(!ready && busy && count == 0, "R8", "ready drop", ready, 0);

        // R4 count mid-run, R7 start during busy ignored
        repeat (10) @(negedge clk);
        check(count == 6'd10, "R4", "mid count", count, 10);
        dividend = 32'hFFFFFFFF; divisor = 16'h0003; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && count == 6'd11, "R7", "count not restarted", count, 11);
        drain();
        check(quotient == 32'd142 && remainder == 16'd6, "R7", "first operands kept",
              quotient, 142);

        // R5 corners
        issue(32'hFFFFFFFF, 16'h0001);
        issue(32'hFFFFFFFF, 16'hFFFF);
        issue(32'h00000000, 16'h1234);
        issue(32'h00000005, 16'h0009);
        issue(32'h80000000, 16'h8000);
        // R5 pseudo-random operands
        lcg = 32'h1234_5678;
        for (int i = 0; i < 12; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            issue(lcg, lcg[23:8] | 16'h0001);
        end
        drain();
        check(exp_q.size() == 0, "R5", "queue empty", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule